// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a byte-wide watchdog down-counter that advances only on pulses of a slow watchdog tick enable. Software controls it through two write-only byte registers. The first is the reload register. The second is the service register, which accepts only a fixed key byte.

The first write to the reload register arms the watchdog. Any later write to the reload register restarts the count with the new value. When keyed servicing is enabled, writing the key byte 0x5C to the service register reloads the counter from the stored reload value.

Writes are accepted in the fast clock domain. They take effect on the next tick, and a busy flag shows that a write is still waiting for that tick. The sticky error output rises on any of three events: the counter underflows, the service register receives a wrong key, or the service register is written twice within one tick period. A freeze input stops the count.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the reload register holds 0x0F, `wdCount` reads 0x0F, `wdErr` is 0, `xferBusy` is 0, and the watchdog is idle.
- R2: While idle, ticks leave `wdCount` unchanged. The first reload write arms the watchdog on the next tick, which loads that value. Each following tick, when not frozen, decrements the count by one.
- R3: A reload write made while armed is stored at once. The next tick loads it into the counter. Of several writes before one tick, the last one is used.
- R4: `xferBusy` rises in the cycle after an accepted write. It falls after the tick that applies the write. A write in the same cycle as a tick is applied by the following tick.
- R5: Suppose `matchEn` is 1, the watchdog is armed, and 0x5C is written to the service register. The next tick then reloads the counter with the stored reload value.
- R6: A service write of any value other than 0x5C while `matchEn` is 1 sets `wdErr` in the next cycle.
- R7: A second service write while `matchEn` is 1, with no tick between the two writes, sets `wdErr`. A write in a tick cycle belongs to the new period.
- R8: While `matchEn` is 0, a service write leaves `xferBusy`, `wdErr` and `wdCount` unchanged.
- R9: While `freeze` is 1, ticks do not decrement the count and do not cause underflow. Pending loads still apply.
- R10: Suppose the watchdog is armed, not frozen, and has no pending load. A tick that finds the count at 0 sets `wdErr`, and the count stays 0. `wdErr` holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wdTick | input | 1 | Watchdog clock enable, one pulse per watchdog period |
| freeze | input | 1 | Halts the count while high |
| matchEn | input | 1 | Enables keyed servicing |
| presetWr | input | 1 | Write strobe of the reload register |
| presetData | input | 8 | Reload value |
| svcWr | input | 1 | Write strobe of the service register |
| svcData | input | 8 | Service key byte |
| wdCount | output | 8 | Current counter value |
| wdErr | output | 1 | Sticky watchdog error |
| xferBusy | output | 1 | A write is waiting for the next tick |

## Verification
Two functions can fall in the same cycle: a register write and the tick that closes a watchdog period. A coinciding write must be credited to the new period, both for busy handling and for double-service detection. The bench provokes this with directed service writes placed just before and exactly on a tick. It also provokes it with random write and tick strobes that often coincide. A second overlap is an underflow tick that meets a pending reload, where the reload must win. A cycle-level reference model in the bench judges every cycle, comparing `wdCount`, `wdErr` and `xferBusy`.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic presetWe;  // capture a new reload value
    logic loadCnt;   // copy reload value into counter
    logic decCnt;    // decrement counter by one
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_keyed_dp.sv
module wdt_keyed_dp
  import wdt_keyed_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] PRESET_INIT = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobe_t       strb,
  input  logic [WIDTH-1:0] presetData,
  output logic [WIDTH-1:0] count,
  output logic             cntZero
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] presetReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presetReg <= PRESET_INIT;
    end else if (strb.presetWe) begin
      presetReg <= presetData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= PRESET_INIT;
    end else if (strb.loadCnt) begin
      count <= presetReg;
    end else if (strb.decCnt) begin
      count <= count - ONE;
    end
  end

  assign cntZero = (count == '0);

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> count == $past(presetReg));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCnt |=> count == $past(count) - ONE);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decCnt && !strb.loadCnt) |-> !cntZero);
endmodule

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl
  import wdt_keyed_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] KEY = 8'h5C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdTick,
  input  logic             freeze,
  input  logic             matchEn,
  input  logic             presetWr,
  input  logic             svcWr,
  input  logic [WIDTH-1:0] svcData,
  input  logic             cntZero,
  output wdtStrobe_t       strb,
  output logic             wdErr,
  output logic             xferBusy
);
  logic running;
  logic presetPend;
  logic svcPend;
  logic svcKeyOk;
  logic svcAccept;
  logic keyBad;
  logic doubleSvc;
  logic svcReload;
  logic countStep;
  logic underflow;

  assign svcAccept = svcWr && matchEn;
  assign keyBad    = svcAccept && (svcData != KEY);
  // a pending service from this period plus a new write, outside a tick cycle
  assign doubleSvc = svcAccept && svcPend && !wdTick;
  assign svcReload = svcPend && svcKeyOk && running;
  assign countStep = wdTick && running && !freeze && !strb.loadCnt;
  assign underflow = countStep && cntZero;

  always_comb begin
    strb          = '0;
    strb.presetWe = presetWr;
    strb.loadCnt  = wdTick && (presetPend || svcReload);
    strb.decCnt   = countStep && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (wdTick && presetPend) begin
      running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presetPend <= 1'b0;
    end else if (presetWr) begin
      presetPend <= 1'b1;
    end else if (wdTick) begin
      presetPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcPend  <= 1'b0;
      svcKeyOk <= 1'b0;
    end else if (svcAccept) begin
      svcPend  <= 1'b1;
      svcKeyOk <= (svcData == KEY);
    end else if (wdTick) begin
      svcPend  <= 1'b0;
      svcKeyOk <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdErr <= 1'b0;
    end else if (keyBad || doubleSvc || underflow) begin
      wdErr <= 1'b1;
    end
  end

  assign xferBusy = presetPend || svcPend;

  // R6
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcWr && matchEn && svcData != KEY) |=> wdErr);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdErr |=> wdErr);

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (presetWr || (svcWr && matchEn)) |=> xferBusy);

  // R8
  svc_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcWr && !matchEn && !presetWr && !xferBusy) |=> !xferBusy);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !strb.decCnt);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] KEY = 8'h5C,
  parameter logic [WIDTH-1:0] PRESET_INIT = 8'h0F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdTick,
  input  logic             freeze,
  input  logic             matchEn,
  input  logic             presetWr,
  input  logic [WIDTH-1:0] presetData,
  input  logic             svcWr,
  input  logic [WIDTH-1:0] svcData,
  output logic [WIDTH-1:0] wdCount,
  output logic             wdErr,
  output logic             xferBusy
);
  wdtStrobe_t strb;
  logic       cntZero;

  wdt_keyed_ctrl #(.WIDTH(WIDTH), .KEY(KEY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wdTick   (wdTick),
    .freeze   (freeze),
    .matchEn  (matchEn),
    .presetWr (presetWr),
    .svcWr    (svcWr),
    .svcData  (svcData),
    .cntZero  (cntZero),
    .strb     (strb),
    .wdErr    (wdErr),
    .xferBusy (xferBusy)
  );

  wdt_keyed_dp #(.WIDTH(WIDTH), .PRESET_INIT(PRESET_INIT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .presetData (presetData),
    .count      (wdCount),
    .cntZero    (cntZero)
  );

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdTick && freeze && !xferBusy) |=> $stable(wdCount));
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
  localparam logic [7:0] KEYB = 8'h5C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wdTick = 1'b0, freeze = 1'b0, matchEn = 1'b0;
  logic       presetWr = 1'b0, svcWr = 1'b0;
  logic [7:0] presetData = '0, svcData = '0;
  logic [7:0] wdCount;
  logic       wdErr, xferBusy;

  int  nTests = 0, nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wdt_keyed i_wdt_keyed (
    .clk(clk), .rstN(rstN), .wdTick(wdTick), .freeze(freeze), .matchEn(matchEn),
    .presetWr(presetWr), .presetData(presetData), .svcWr(svcWr), .svcData(svcData),
    .wdCount(wdCount), .wdErr(wdErr), .xferBusy(xferBusy)
  );

  // Reference model built from the requirements
  logic [7:0] mPreset, mCnt;
  logic       mRun, mErr, mPP, mSP, mOk;

  function automatic logic [7:0] nextCount(logic [7:0] cnt, logic [7:0] pre, logic load,
                                           logic step);
    if (load) return pre;
    if (step && cnt != 8'd0) return cnt - 8'd1;
    return cnt;
  endfunction

  always @(posedge clk) begin : model
    logic load, step;
    if (!rstN) begin
      mPreset = 8'h0F; mCnt = 8'h0F; mRun = 0; mErr = 0; mPP = 0; mSP = 0; mOk = 0;
    end else begin
      load = wdTick && (mPP || (mSP && mOk && mRun));
      step = wdTick && mRun && !freeze && !load;
      if (step && mCnt == 8'd0) mErr = 1;                                  // R10
      if (svcWr && matchEn && (svcData != KEYB || (mSP && !wdTick))) mErr = 1; // R6 R7
      mCnt = nextCount(mCnt, mPreset, load, step);
      if (wdTick && mPP) mRun = 1;
      if (presetWr) begin mPreset = presetData; mPP = 1; end
      else if (wdTick) mPP = 0;
      if (svcWr && matchEn) begin mSP = 1; mOk = (svcData == KEYB); end
      else if (wdTick) begin mSP = 0; mOk = 0; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cmpModel(string tag);
    chk({tag, " count"}, wdCount, mCnt);
    chk({tag, " err"}, wdErr, mErr);
    chk({tag, " busy"}, xferBusy, mPP || mSP);
  endtask

  // Drive at negedge, let one edge pass, return at the next negedge.
  task automatic cyc(string tag, bit tk = 0, bit pw = 0, logic [7:0] pd = 0,
                     bit sw = 0, logic [7:0] sd = 0);
    wdTick = tk; presetWr = pw; presetData = pd; svcWr = sw; svcData = sd;
    @(posedge clk);
    @(negedge clk);
    wdTick = 0; presetWr = 0; svcWr = 0;
    cmpModel(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; wdTick = 0; presetWr = 0; svcWr = 0; freeze = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    doReset();
    // R1 reset state
    chk("R1 count", wdCount, 8'h0F);
    chk("R1 err", wdErr, 0);
    chk("R1 busy", xferBusy, 0);
    // R2 idle until first reload write
    repeat (3) cyc("R2 idle", 1);
    chk("R2 idle count", wdCount, 8'h0F);
    cyc("R4 busy up", 0, 1, 8'd5);
    chk("R4 busy", xferBusy, 1);
    cyc("R2 arm", 1);
    chk("R2 load", wdCount, 8'd5);
    chk("R4 busy down", xferBusy, 0);
    cyc("R2 dec", 1);
    cyc("R2 dec", 1);
    chk("R2 count", wdCount, 8'd3);
    // R5 keyed service
    matchEn = 1;
    cyc("R5 svc", 0, 0, 0, 1, KEYB);
    cyc("R5 tick", 1);
    chk("R5 reload", wdCount, 8'd5);
    // R8 ignored service
    matchEn = 0;
    cyc("R8 write", 0, 0, 0, 1, 8'h33);
    chk("R8 busy", xferBusy, 0);
    cyc("R8 tick", 1);
    chk("R8 count", wdCount, 8'd4);
    chk("R8 err", wdErr, 0);
    // R9 freeze
    freeze = 1;
    cyc("R9 frz", 1);
    cyc("R9 frz", 1);
    chk("R9 hold", wdCount, 8'd4);
    cyc("R9 pend", 0, 1, 8'd2);
    cyc("R9 load", 1);
    chk("R9 load", wdCount, 8'd2);
    freeze = 0;
    // R3 later reload write, last of two wins
    cyc("R3 w1", 0, 1, 8'd9);
    cyc("R3 w2", 0, 1, 8'd7);
    cyc("R3 tick", 1);
    chk("R3 reload", wdCount, 8'd7);
    // R7 boundary: write then write in tick cycle is fine
    matchEn = 1;
    cyc("R7 a", 0, 0, 0, 1, KEYB);
    cyc("R7 b", 1, 0, 0, 1, KEYB);
    chk("R7 boundary", wdErr, 0);
    cyc("R7 c", 0, 0, 0, 1, KEYB);
    chk("R7 double", wdErr, 1);
    // R6 wrong key
    doReset();
    matchEn = 1;
    cyc("R6 arm", 0, 1, 8'd4);
    cyc("R6 tick", 1);
    cyc("R6 bad", 0, 0, 0, 1, 8'h12);
    chk("R6 err", wdErr, 1);
    // R10 underflow
    doReset();
    cyc("R10 arm", 0, 1, 8'd1);
    cyc("R10 load", 1);
    cyc("R10 dec", 1);
    chk("R10 zero", wdCount, 8'd0);
    chk("R10 noerr", wdErr, 0);
    cyc("R10 under", 1);
    chk("R10 err", wdErr, 1);
    repeat (3) cyc("R10 sticky", 1);
    chk("R10 sticky", wdErr, 1);
    chk("R10 count", wdCount, 8'd0);

    // Constrained random segments
    for (int seg = 0; seg < 20; seg++) begin
      doReset();
      matchEn = ($urandom % 3) != 0;
      for (int c = 0; c < 400; c++) begin
        freeze = ($urandom % 8) == 0;
        cyc("random",
            ($urandom % 4) == 0,
            ($urandom % 16) == 0, 8'(1 + $urandom % 12),
            ($urandom % 6) == 0,
            (($urandom % 10) == 0) ? 8'($urandom) : KEYB);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule